// File: doc/BRIEF.md
# Two-way signalled atomic register

This block stores one multi-bit value that a single writer updates and a single reader samples, and it keeps the reader's successive results in order. It is built from two plainer storage elements. One is a shared word that only the writer changes. It holds the value being replaced, the value being installed, a step number from 1 to 3 and a one-bit colour. The other is a one-bit colour flag that only the reader changes.

An update of the value proceeds as follows:
- The writer takes the complement of the reader's colour flag as its working colour.
- Over three consecutive clock edges it installs three tagged words. Each carries the prior value, the incoming value, the step number (1, 2, then 3) and the working colour.
- A word at step 3 stands for its incoming value.

A read proceeds as follows:
- The reader samples the shared word and returns a value according to these rules:
  - A step-3 word gives its incoming value.
  - A step-1 or step-2 word whose colour matches the reader's recorded colour gives the value the reader returned last time.
  - Any other step-1 or step-2 word gives its prior value.
- The reader then records the colour it saw.

Neither side ever stalls for the other. A read may land on any step of an update.

Top module: `atomreg_color`

## Requirements
- R1: After reset, wr_done and rd_valid are low. The stored value is the parameter INIT_VAL (default 0), so a first read that meets no update returns INIT_VAL.
- R2: A wr_req seen at a clock edge while no update is in progress is accepted at that edge. wr_done is then high for exactly the one cycle that follows the third clock edge, counting the accept edge as the first.
- R3: A wr_req seen at an edge while an update is in progress is dropped. It produces no wr_done, and its wr_value is never returned by a read.
- R4: rd_valid is high in the cycle after each edge at which rd_req is high, and low after each edge at which rd_req is low.
- R5: A read that meets no update in progress returns the value of the most recently completed update (or INIT_VAL).
- R6: A read sampling a step-1 or step-2 word returns the value the reader last returned if the word's colour equals the colour the reader last recorded. Otherwise it returns the word's prior value. At the start of each update the working colour is the complement of the reader's recorded colour.
- R7: Values returned by successive reads never go from an update's incoming value back to its prior value.
- R8: A read at an edge where the shared word is at step 3 returns that word's incoming value. In particular, this holds for a read issued in the cycle in which wr_done is high.
- R9: A read at the same edge at which an update is accepted returns the value held before that update.
- R10: Reads may be issued on every cycle, back to back, while updates run continuously. Each read obeys R5 to R8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_req | input | 1 | Request to install wr_value |
| wr_value | input | DATA_W | Value to install |
| wr_done | output | 1 | One-cycle pulse when the third tagged word is in place |
| rd_req | input | 1 | Request to sample the register |
| rd_value | output | DATA_W | Value returned by the last read |
| rd_valid | output | 1 | rd_value holds a fresh read result |

## Verification
Two pairs of events can share a clock edge:
- a read sampling the shared word while the writer replaces it;
- the writer sampling the reader's colour flag while the reader rewrites that flag.

The bench provokes both pairs with a sweep of every pattern of read slots across a six-cycle window around each update. A second stretch keeps a read on every cycle while updates run with no gaps. Each result is judged against a step-by-step model of the tag and colour rules, and against the rule that returned values never step backwards. Update values rise strictly, so that rule reduces to a check that returned values never decrease.

// File: rtl/atomreg_pkg.sv
package atomreg_pkg;

   // step number carried in the shared word
   typedef enum logic [1:0] {
      PH_NONE  = 2'd0,
      PH_ONE   = 2'd1,
      PH_TWO   = 2'd2,
      PH_THREE = 2'd3
   } phase_e;

   // writer sequencing state
   typedef enum logic [1:0] {
      WS_IDLE = 2'd0,
      WS_P2   = 2'd1,
      WS_P3   = 2'd2
   } wstate_e;

   localparam int unsigned PHASE_W = 2;

endpackage

// File: rtl/atomreg_store.sv
module atomreg_store
   import atomreg_pkg::*;
#(
   parameter int unsigned DATA_W = 8,
   parameter logic [DATA_W-1:0] INIT_VAL = '0,
   localparam int unsigned WORD_W = 2 * DATA_W + PHASE_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              word_we,
   input  logic [WORD_W-1:0] word_wdata,
   input  logic              color_we,
   input  logic              color_wdata,
   output logic [WORD_W-1:0] word_q,
   output logic              color_q
);

   generate
      if (DATA_W < 1) begin : g_bad_width
         $error("atomreg_store: DATA_W must be at least 1");
      end
   endgenerate

   localparam logic [WORD_W-1:0] WORD_RESET = {INIT_VAL, INIT_VAL, PH_THREE, 1'b0};

   // shared word: only the writer drives word_we
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         word_q <= WORD_RESET;
      end else if (word_we) begin
         word_q <= word_wdata;
      end
   end

   // colour flag: only the reader drives color_we
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         color_q <= 1'b0;
      end else if (color_we) begin
         color_q <= color_wdata;
      end
   end

endmodule

// File: rtl/atomreg_writer.sv
module atomreg_writer
   import atomreg_pkg::*;
#(
   parameter int unsigned DATA_W = 8,
   localparam int unsigned WORD_W = 2 * DATA_W + PHASE_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_req,
   input  logic [DATA_W-1:0] wr_value,
   input  logic [DATA_W-1:0] cur_new,
   input  logic              color_in,
   output logic              word_we,
   output logic [WORD_W-1:0] word_wdata,
   output logic              wr_done
);

   wstate_e           state_q;
   logic [DATA_W-1:0] prior_q;
   logic [DATA_W-1:0] incoming_q;
   logic              work_col_q;

   always_comb begin
      word_we    = 1'b0;
      word_wdata = {prior_q, incoming_q, PH_TWO, work_col_q};
      unique case (state_q)
         WS_IDLE: begin
            if (wr_req) begin
               word_we    = 1'b1;
               word_wdata = {cur_new, wr_value, PH_ONE, ~color_in};
            end
         end
         WS_P2: begin
            word_we    = 1'b1;
            word_wdata = {prior_q, incoming_q, PH_TWO, work_col_q};
         end
         WS_P3: begin
            word_we    = 1'b1;
            word_wdata = {prior_q, incoming_q, PH_THREE, work_col_q};
         end
         default: begin
            word_we = 1'b0;
         end
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q    <= WS_IDLE;
         prior_q    <= '0;
         incoming_q <= '0;
         work_col_q <= 1'b0;
         wr_done    <= 1'b0;
      end else begin
         wr_done <= 1'b0;
         unique case (state_q)
            WS_IDLE: begin
               if (wr_req) begin
                  prior_q    <= cur_new;
                  incoming_q <= wr_value;
                  work_col_q <= ~color_in;
                  state_q    <= WS_P2;
               end
            end
            WS_P2: state_q <= WS_P3;
            WS_P3: begin
               state_q <= WS_IDLE;
               wr_done <= 1'b1;
            end
            default: state_q <= WS_IDLE;
         endcase
      end
   end

   // a request arriving mid-update leaves the latched incoming value alone
   p_busy_keeps_value_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q != WS_IDLE && state_q != WS_P3) |=> $stable(incoming_q));

endmodule

// File: rtl/atomreg_reader.sv
module atomreg_reader
   import atomreg_pkg::*;
#(
   parameter int unsigned DATA_W = 8,
   parameter logic [DATA_W-1:0] INIT_VAL = '0,
   localparam int unsigned WORD_W = 2 * DATA_W + PHASE_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_req,
   input  logic [WORD_W-1:0] word_in,
   input  logic              color_rec,
   output logic              color_we,
   output logic              color_wdata,
   output logic [DATA_W-1:0] rd_value,
   output logic              rd_valid
);

   logic [DATA_W-1:0] f_prior;
   logic [DATA_W-1:0] f_incoming;
   phase_e            f_phase;
   logic              f_col;
   logic [DATA_W-1:0] pick;

   assign f_col      = word_in[0];
   assign f_phase    = phase_e'(word_in[PHASE_W:1]);
   assign f_incoming = word_in[PHASE_W+DATA_W:PHASE_W+1];
   assign f_prior    = word_in[WORD_W-1:PHASE_W+DATA_W+1];

   always_comb begin
      if (f_phase == PH_THREE) begin
         pick = f_incoming;
      end else if (f_col == color_rec) begin
         pick = rd_value;
      end else begin
         pick = f_prior;
      end
   end

   assign color_we    = rd_req;
   assign color_wdata = f_col;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_value <= INIT_VAL;
         rd_valid <= 1'b0;
      end else begin
         rd_valid <= rd_req;
         if (rd_req) begin
            rd_value <= pick;
         end
      end
   end

   p_valid_follows_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req |=> rd_valid);
   p_no_valid_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_req |=> !rd_valid);
   p_step3_gives_new_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && f_phase == PH_THREE) |=> (rd_value == $past(f_incoming)));
   p_color_recorded_r7: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req |=> (color_rec == $past(f_col)));

endmodule

// File: rtl/atomreg_color.sv
module atomreg_color
   import atomreg_pkg::*;
#(
   parameter int unsigned DATA_W = 8,
   parameter logic [DATA_W-1:0] INIT_VAL = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_req,
   input  logic [DATA_W-1:0] wr_value,
   output logic              wr_done,
   input  logic              rd_req,
   output logic [DATA_W-1:0] rd_value,
   output logic              rd_valid
);

   localparam int unsigned WORD_W = 2 * DATA_W + PHASE_W + 1;

   generate
      if (DATA_W > 64) begin : g_too_wide
         $error("atomreg_color: DATA_W above 64 is not supported");
      end
   endgenerate

   logic              word_we;
   logic [WORD_W-1:0] word_wdata;
   logic [WORD_W-1:0] word_q;
   logic              color_we;
   logic              color_wdata;
   logic              color_q;
   phase_e            cur_phase;

   assign cur_phase = phase_e'(word_q[PHASE_W:1]);

   atomreg_store #(.DATA_W(DATA_W), .INIT_VAL(INIT_VAL)) u_store (
      .clk        (clk),
      .rst_n      (rst_n),
      .word_we    (word_we),
      .word_wdata (word_wdata),
      .color_we   (color_we),
      .color_wdata(color_wdata),
      .word_q     (word_q),
      .color_q    (color_q)
   );

   atomreg_writer #(.DATA_W(DATA_W)) u_writer (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_req    (wr_req),
      .wr_value  (wr_value),
      .cur_new   (word_q[PHASE_W+DATA_W:PHASE_W+1]),
      .color_in  (color_q),
      .word_we   (word_we),
      .word_wdata(word_wdata),
      .wr_done   (wr_done)
   );

   atomreg_reader #(.DATA_W(DATA_W), .INIT_VAL(INIT_VAL)) u_reader (
      .clk        (clk),
      .rst_n      (rst_n),
      .rd_req     (rd_req),
      .word_in    (word_q),
      .color_rec  (color_q),
      .color_we   (color_we),
      .color_wdata(color_wdata),
      .rd_value   (rd_value),
      .rd_valid   (rd_valid)
   );

   p_step1_then_2_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_phase == PH_ONE) |=> (cur_phase == PH_TWO));
   p_step2_then_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_phase == PH_TWO) |=> (cur_phase == PH_THREE && wr_done));
   p_done_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_done |=> !wr_done);

endmodule

// File: tb/tb_atomreg_color.sv
module tb_atomreg_color;

   localparam int unsigned W = 8;
   localparam logic [W-1:0] IGN = 8'hFF;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         wr_req = 1'b0;
   logic [W-1:0] wr_value = '0;
   logic         rd_req = 1'b0;
   logic         wr_done;
   logic [W-1:0] rd_value;
   logic         rd_valid;

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   // reference state
   logic [W-1:0] m_old = '0, m_new = '0, m_last = '0, next_val = 8'd1, prev_ret = '0;
   logic [1:0]   m_ph = 2'd3;
   logic         m_col = 1'b0, m_c = 1'b0;
   int           m_ws = 0;
   bit           dense = 0;

   always #5 clk = ~clk;

   atomreg_color #(.DATA_W(W), .INIT_VAL('0)) dut (
      .clk(clk), .rst_n(rst_n), .wr_req(wr_req), .wr_value(wr_value),
      .wr_done(wr_done), .rd_req(rd_req), .rd_value(rd_value), .rd_valid(rd_valid)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic step(input logic wq, input logic [W-1:0] wv, input logic rq);
      logic [W-1:0] res = '0;
      logic         c_pre;
      bit           e_done = 0;
      string        tag = "R5";
      @(negedge clk);
      wr_req = wq; wr_value = wv; rd_req = rq;
      @(posedge clk);
      c_pre = m_c;
      if (rq) begin
         if (m_ph == 2'd3) res = m_new;
         else if (m_col == m_c) res = m_last;
         else res = m_old;
         if (dense) tag = "R10";
         else if (wq && m_ws == 0) tag = "R9";
         else if (m_ws != 0 || m_ph != 2'd3) tag = "R6";
         else tag = "R5";
         if (m_ph == 2'd3 && m_ws == 0 && !wq && !dense) tag = "R8";
         m_c = m_col;
         m_last = res;
      end
      if (m_ws == 0 && wq) begin
         m_old = m_new; m_new = wv; m_ph = 2'd1; m_col = ~c_pre; m_ws = 1;
      end else if (m_ws == 1) begin
         m_ph = 2'd2; m_ws = 2;
      end else if (m_ws == 2) begin
         m_ph = 2'd3; m_ws = 0; e_done = 1;
      end
      #1;
      check(wr_done == e_done, "R2", wr_done, e_done);
      if (rq) begin
         check(rd_valid == 1'b1, "R4", rd_valid, 1);
         check(rd_value == res, tag, rd_value, res);
         check(rd_value >= prev_ret, "R7", rd_value, prev_ret);
         check(rd_value != IGN, "R3", rd_value, res);
         prev_ret = rd_value;
      end else begin
         check(rd_valid == 1'b0, "R4", rd_valid, 0);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R1: reset state
      check(rd_valid == 1'b0, "R1", rd_valid, 0);
      check(wr_done == 1'b0, "R1", wr_done, 0);
      step(1'b0, '0, 1'b1);
      check(rd_value == '0, "R1", rd_value, 0);

      // sweep of read slots around each update, with dropped mid-update requests (R3)
      for (int p = 0; p < 128; p++) begin
         step(1'b1, next_val, p[0]);
         next_val++;
         step(p[6], IGN, p[1]);
         step(1'b0, '0, p[2]);
         step(1'b0, '0, p[3]);
         step(1'b0, '0, p[4]);
         step(1'b0, '0, p[5]);
      end

      // R10: read on every cycle while updates run back to back
      dense = 1;
      for (int t = 0; t < 200; t++) begin
         if (m_ws == 0) begin
            step(1'b1, next_val, 1'b1);
            next_val++;
         end else begin
            step(1'b1, IGN, 1'b1);
         end
      end
      dense = 0;
      step(1'b0, '0, 1'b0);
      step(1'b0, '0, 1'b1);
      check(rd_value == next_val - 8'd1, "R5", rd_value, next_val - 8'd1);

      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule